// File: doc/BRIEF.md
# 64-bit Periodic Interval Timer

A memory-mapped timer peripheral for a single-clock system. Its 64-bit counter advances once per prescaled tick. A tick comes from one of two sources: every bus clock cycle, or a synchronous strobe that marks the edges of a slower auxiliary clock. That source is divided by a 4-bit prescaler. The counter runs against a programmable 64-bit period, in either continuous or one-shot mode. Each time the period is reached it sets a status flag. The flag drives a level interrupt through an enable bit.

Software reaches the block with plain read and write strobes on a 32-bit data word. The usual setup order is: soft reset, mode, period upper word, period lower word, interrupt enable, start. The 64-bit period is committed as one value when its lower word is written. The 64-bit count is read as two words. Reading the lower word captures the upper word, so the pair is always coherent, however long the gap before the upper-word read.

The control logic is a three-state machine. IDLE is the state after reset or soft reset. RUN is counting. HALT is a one-shot that has expired. The transitions are:
- GO: IDLE to RUN, on start.
- ONESHOT_END: RUN to HALT, when the period is reached in one-shot mode.
- REARM: HALT to RUN, on start.
- SOFT_RESET: any state to IDLE.

Top module: `pit64_timer`

## Requirements
- R1: After reset every register reads zero: mode, period words, interrupt enable, status and count. The interrupt output is low.
- R2: A control write (offset 0x00) with bit 8 set is a soft reset. It stops counting, clears the count and the status flag, and takes priority over bit 0 in the same write.
- R3: A control write with bit 0 set (and bit 8 clear) starts the timer when it is stopped. The count restarts at zero and the prescaler phase is cleared. The same write while the timer is running has no effect on the count.
- R4: Mode register (offset 0x04) bit 3 selects the tick source: 1 selects the auxiliary strobe `aux_tick`, 0 selects the bus clock. Strobes on `aux_tick` are separated by at least two idle cycles. The mode fields read back at the same positions.
- R5: Mode bits 11:8 hold a prescaler value p. The counter advances once per p+1 source events, counted from the start.
- R6: In continuous mode (mode bit 0 = 1) with period P, the count runs 0..P-1 and wraps to zero. The status flag is set every P ticks. A period of zero behaves as 2^64.
- R7: In one-shot mode (mode bit 0 = 0), the count reaches P and the flag is set. The count then holds at P and counting stops until the next start.
- R8: A write to offset 0x0C only stages the upper period word. A write to offset 0x08 commits the staged upper word and the written lower word together as the active period. Offset 0x0C reads the staged word; offset 0x08 reads the active lower word.
- R9: Reading offset 0x20 returns the live lower count word and captures the upper count word. Offset 0x24 returns that captured word until the next read of 0x20.
- R10: Offset 0x1C bit 0 reads the status flag, and the read clears it. If the period is reached in the same cycle as the read, the set wins and the flag stays set.
- R11: Offset 0x10 bit 0 enables the interrupt and reads back. `irq` is high exactly when the status flag and this bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read side effects happen at the clock edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data for `bus_addr`, valid in the same cycle |
| aux_tick | input | 1 | One-cycle strobe per auxiliary clock edge |
| irq | output | 1 | Level period interrupt |

## Verification
Two collisions are provoked on purpose. The first is the period being reached in the same cycle as a status read. The bench waits until exactly one tick is left in a one-shot run, then issues the status read. It expects that read to return 0, the next read to return 1 with `irq` high, and the read after that to return 0. The second collision is between the count capture and a carry into the upper word. The bench reads the lower count word at 0xFFFF and reads the upper word only after the carry has happened. The old captured upper word is expected. Randomly mixed modes, sources, prescalers and periods are checked against counts the bench derives from the number of source events it has seen since the start.

// File: rtl/pit64_pkg.sv
package pit64_pkg;

    localparam int PRES_W = 4;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_MODE   = 8'h04;
    localparam logic [7:0] OFS_PER_LO = 8'h08;
    localparam logic [7:0] OFS_PER_HI = 8'h0C;
    localparam logic [7:0] OFS_IEN    = 8'h10;
    localparam logic [7:0] OFS_STAT   = 8'h1C;
    localparam logic [7:0] OFS_CNT_LO = 8'h20;
    localparam logic [7:0] OFS_CNT_HI = 8'h24;

    localparam int BIT_START   = 0;
    localparam int BIT_SRST    = 8;
    localparam int BIT_CONT    = 0;
    localparam int BIT_AUX     = 3;
    localparam int BIT_PRES_LO = 8;
    localparam int BIT_IEN     = 0;
    localparam int BIT_FLAG    = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } run_state_t;

endpackage

// File: rtl/pit64_regs.sv
module pit64_regs
    import pit64_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              flag_i,
    output logic              mode_cont_o,
    output logic              mode_aux_o,
    output logic [PRES_W-1:0] mode_pres_o,
    output logic [CNT_W-1:0]  period_o,
    output logic              ien_o,
    output logic              start_o,
    output logic              srst_o,
    output logic              stat_rd_o
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_PER_LO = ADDR_W'(OFS_PER_LO);
    localparam logic [ADDR_W-1:0] A_PER_HI = ADDR_W'(OFS_PER_HI);
    localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(OFS_IEN);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFS_CNT_LO);
    localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFS_CNT_HI);

    logic              cont_q;
    logic              aux_q;
    logic [PRES_W-1:0] pres_q;
    logic [WORD_W-1:0] stage_q;
    logic [CNT_W-1:0]  period_q;
    logic              ien_q;
    logic [WORD_W-1:0] hi_cap_q;

    logic sel_ctrl, sel_mode, sel_plo, sel_phi, sel_ien, sel_stat, sel_clo;
    logic wr_plo, rd_clo;
    logic [WORD_W-1:0] rd_word;

    // address decode
    always_comb begin
        sel_ctrl = (bus_addr == A_CTRL);
        sel_mode = (bus_addr == A_MODE);
        sel_plo  = (bus_addr == A_PER_LO);
        sel_phi  = (bus_addr == A_PER_HI);
        sel_ien  = (bus_addr == A_IEN);
        sel_stat = (bus_addr == A_STAT);
        sel_clo  = (bus_addr == A_CNT_LO);
        wr_plo   = bus_wr && sel_plo;
        rd_clo   = bus_rd && sel_clo;
    end

    // control strobes: soft reset dominates start
    always_comb begin
        srst_o    = bus_wr && sel_ctrl && bus_wdata[BIT_SRST];
        start_o   = bus_wr && sel_ctrl && bus_wdata[BIT_START] && !bus_wdata[BIT_SRST];
        stat_rd_o = bus_rd && sel_stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cont_q   <= 1'b0;
            aux_q    <= 1'b0;
            pres_q   <= '0;
            stage_q  <= '0;
            period_q <= '0;
            ien_q    <= 1'b0;
        end else if (bus_wr) begin
            if (sel_mode) begin
                cont_q <= bus_wdata[BIT_CONT];
                aux_q  <= bus_wdata[BIT_AUX];
                pres_q <= bus_wdata[BIT_PRES_LO +: PRES_W];
            end
            if (sel_phi) begin
                stage_q <= bus_wdata;
            end
            if (sel_plo) begin
                period_q <= {stage_q, bus_wdata};
            end
            if (sel_ien) begin
                ien_q <= bus_wdata[BIT_IEN];
            end
        end
    end

    // upper count word captured on every lower-word read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cap_q <= '0;
        end else if (rd_clo) begin
            hi_cap_q <= cnt_i[CNT_W-1:WORD_W];
        end
    end

    always_comb begin
        rd_word = '0;
        case (bus_addr)
            A_MODE: begin
                rd_word[BIT_CONT]               = cont_q;
                rd_word[BIT_AUX]                = aux_q;
                rd_word[BIT_PRES_LO +: PRES_W]  = pres_q;
            end
            A_PER_LO: rd_word = period_q[WORD_W-1:0];
            A_PER_HI: rd_word = stage_q;
            A_IEN:    rd_word[BIT_IEN] = ien_q;
            A_STAT:   rd_word[BIT_FLAG] = flag_i;
            A_CNT_LO: rd_word = cnt_i[WORD_W-1:0];
            A_CNT_HI: rd_word = hi_cap_q;
            default:  rd_word = '0;
        endcase
    end

    assign bus_rdata   = rd_word;
    assign mode_cont_o = cont_q;
    assign mode_aux_o  = aux_q;
    assign mode_pres_o = pres_q;
    assign period_o    = period_q;
    assign ien_o       = ien_q;

    AST_HI_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clo |=> $stable(hi_cap_q)) else $error("captured upper word moved"); // R9
    AST_PERIOD_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_plo |=> $stable(period_q)) else $error("active period changed without commit"); // R8

endmodule

// File: rtl/pit64_presc.sv
module pit64_presc
    import pit64_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              clear_i,
    input  logic              aux_sel_i,
    input  logic              aux_tick_i,
    input  logic [PRES_W-1:0] pres_i,
    output logic              tick_o
);

    logic [PRES_W-1:0] div_q;
    logic              src_ev;
    logic              wrap;

    always_comb begin
        src_ev = aux_sel_i ? aux_tick_i : 1'b1;
        wrap   = (div_q >= pres_i);
        tick_o = run_i && src_ev && wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clear_i) begin
            div_q <= '0;
        end else if (run_i && src_ev) begin
            if (wrap) begin
                div_q <= '0;
            end else begin
                div_q <= div_q + PRES_W'(1);
            end
        end
    end

    AST_AUX_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        aux_tick_i |=> !aux_tick_i ##1 !aux_tick_i) else $error("auxiliary strobes too close"); // R4
    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (div_q == '0)) else $error("prescaler phase not cleared"); // R5

endmodule

// File: rtl/pit64_core.sv
module pit64_core
    import pit64_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             srst_i,
    input  logic             tick_i,
    input  logic             cont_i,
    input  logic             stat_rd_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output logic             run_o,
    output logic             restart_o
);

    run_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             flag_q;
    logic             go;
    logic             hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: GO, ONESHOT_END, REARM, SOFT_RESET
    always_comb begin
        state_d = state_q;
        if (srst_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) state_d = ST_RUN;
                ST_RUN:  if (hit && !cont_i) state_d = ST_HALT;
                ST_HALT: if (start_i) state_d = ST_RUN;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs of the state machine
    always_comb begin
        cnt_inc   = cnt_q + CNT_W'(1);
        run_o     = (state_q == ST_RUN);
        go        = start_i && (state_q != ST_RUN);
        hit       = run_o && tick_i && (cnt_inc == period_i);
        restart_o = go || srst_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (srst_i || go) begin
            cnt_q <= '0;
        end else if (run_o && tick_i) begin
            if (hit && cont_i) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_inc;
            end
        end
    end

    // set beats read-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (srst_i) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (stat_rd_i) begin
            flag_q <= 1'b0;
        end
    end

    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && stat_rd_i) |=> flag_q) else $error("set lost against read"); // R10
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !hit && !srst_i) |=> !flag_q) else $error("flag survived read"); // R10
    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (cnt_q == '0) && !flag_q && (state_q == ST_IDLE)) else $error("soft reset incomplete"); // R2
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !start_i && !srst_i) |=> $stable(cnt_q) && (state_q == ST_HALT)) else $error("one-shot moved after expiry"); // R7

endmodule

// File: rtl/pit64_timer.sv
module pit64_timer
    import pit64_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              aux_tick,
    output logic              irq
);

    localparam int CNT_W = 2 * WORD_W;

    logic              mode_cont, mode_aux, ien;
    logic [PRES_W-1:0] mode_pres;
    logic [CNT_W-1:0]  period, cnt;
    logic              start, srst, stat_rd;
    logic              flag, run, restart, tick;

    pit64_regs #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cnt_i       (cnt),
        .flag_i      (flag),
        .mode_cont_o (mode_cont),
        .mode_aux_o  (mode_aux),
        .mode_pres_o (mode_pres),
        .period_o    (period),
        .ien_o       (ien),
        .start_o     (start),
        .srst_o      (srst),
        .stat_rd_o   (stat_rd)
    );

    pit64_presc u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .clear_i    (restart),
        .aux_sel_i  (mode_aux),
        .aux_tick_i (aux_tick),
        .pres_i     (mode_pres),
        .tick_o     (tick)
    );

    pit64_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .srst_i    (srst),
        .tick_i    (tick),
        .cont_i    (mode_cont),
        .stat_rd_i (stat_rd),
        .period_i  (period),
        .cnt_o     (cnt),
        .flag_o    (flag),
        .run_o     (run),
        .restart_o (restart)
    );

    assign irq = flag && ien;

endmodule

// File: tb/pit64_timer_bench.sv
module pit64_timer_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         aux_tick = 1'b0;
    logic         irq;

    int unsigned cyc = 0, aux_cnt = 0;
    int unsigned wr_cyc, wr_aux, smp_cyc, smp_aux;
    logic        smp_irq;
    int unsigned c0, a0;
    int          total = 0, fails = 0;

    pit64_timer #(.WORD_W(W), .ADDR_W(8)) u_pit64_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .aux_tick(aux_tick), .irq(irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (aux_tick) aux_cnt <= aux_cnt + 1;
    end

    // auxiliary strobe: random, at least two idle cycles between strobes
    initial begin
        int gap = 0;
        forever begin
            @(negedge clk);
            if (gap >= 2 && ($urandom % 2) == 1) begin
                aux_tick = 1'b1;
                gap = 0;
            end else begin
                aux_tick = 1'b0;
                gap++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int unsigned act, input int unsigned exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [7:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        wr_cyc = cyc; wr_aux = aux_cnt;
    endtask

    task automatic brd(input logic [7:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata; smp_cyc = cyc; smp_aux = aux_cnt; smp_irq = irq;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic start_run();
        bwr(8'h00, 16'h0001);
        c0 = wr_cyc; a0 = wr_aux;
    endtask

    task automatic wait_until(input int unsigned t);
        while ((cyc - c0) < t) begin
            @(posedge clk); #1;
        end
    endtask

    function automatic int unsigned exp_count(int unsigned ev, int unsigned pres, int unsigned per, bit cont);
        int unsigned t = ev / (pres + 1);
        if (cont) return t % per;
        return (t >= per) ? per : t;
    endfunction

    function automatic bit exp_flag(int unsigned ev, int unsigned pres, int unsigned per);
        return (ev / (pres + 1)) >= per;
    endfunction

    task automatic setup(input logic [W-1:0] mode, input logic [W-1:0] plo, input logic [W-1:0] ien);
        bwr(8'h00, 16'h0100);
        bwr(8'h04, mode);
        bwr(8'h0C, 16'h0000);
        bwr(8'h08, plo);
        bwr(8'h10, ien);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", cyc, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [W-1:0] d;
        int unsigned  ev;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        brd(8'h04, d); check(d == 0, "R1 mode", d, 0);
        brd(8'h08, d); check(d == 0, "R1 period low", d, 0);
        brd(8'h0C, d); check(d == 0, "R1 period high", d, 0);
        brd(8'h10, d); check(d == 0, "R1 enable", d, 0);
        brd(8'h1C, d); check(d == 0, "R1 status", d, 0);
        brd(8'h20, d); check(d == 0, "R1 count", d, 0);
        check(smp_irq == 1'b0, "R1 irq", smp_irq, 0);

        // R4 R5: mode fields read back at their positions
        bwr(8'h04, 16'h0F09);
        brd(8'h04, d); check(d == 16'h0F09, "R4 R5 mode readback", d, 16'h0F09);

        // R8: staged upper word does not touch the active period
        setup(16'h0001, 16'd5, 16'h0001);
        bwr(8'h0C, 16'h0001);
        brd(8'h0C, d); check(d == 16'h0001, "R8 staged readback", d, 1);
        brd(8'h08, d); check(d == 16'd5, "R8 active low readback", d, 5);
        start_run();
        wait_until(12);
        brd(8'h20, d); ev = smp_cyc - c0;
        check(d == W'(ev % 5), "R8 R6 period still 5", d, ev % 5);
        brd(8'h10, d); check(d == 16'h0001, "R11 enable readback", d, 1);

        // R3: start while running is ignored
        setup(16'h0001, 16'h0000, 16'h0000);
        start_run();
        wait_until(20);
        bwr(8'h00, 16'h0001);
        wait_until(40);
        brd(8'h20, d); ev = smp_cyc - c0;
        check(d == W'(ev), "R3 restart ignored while running", d, ev);

        // R2: soft reset beats start in the same write
        bwr(8'h00, 16'h0101);
        repeat (10) @(negedge clk);
        brd(8'h20, d); check(d == 0, "R2 count cleared and stopped", d, 0);
        brd(8'h1C, d); check(d == 0, "R2 status cleared", d, 0);

        // R5: largest prescaler on the bus clock
        setup(16'h0F01, 16'h0000, 16'h0000);
        start_run();
        wait_until(100);
        brd(8'h20, d); ev = smp_cyc - c0;
        check(d == W'(ev / 16), "R5 divide by 16", d, ev / 16);

        // R10 R7 R11: period reached in the same cycle as a status read
        setup(16'h0000, 16'd6, 16'h0001);
        start_run();
        wait_until(5);
        brd(8'h1C, d); check(d == 0, "R10 status before hit", d, 0);
        brd(8'h1C, d); check(d == 1, "R10 set wins over clear", d, 1);
        check(smp_irq == 1'b1, "R11 irq with flag and enable", smp_irq, 1);
        brd(8'h1C, d); check(d == 0, "R10 read clears", d, 0);
        check(smp_irq == 1'b0, "R11 irq low after clear", smp_irq, 0);
        repeat (20) @(negedge clk);
        brd(8'h20, d); check(d == 16'd6, "R7 one-shot holds at period", d, 6);
        start_run();
        wait_until(3);
        brd(8'h20, d); ev = smp_cyc - c0;
        check(d == W'(ev), "R3 R7 restart from halt", d, ev);

        // R9: upper word captured before the carry
        setup(16'h0001, 16'h0000, 16'h0000);
        start_run();
        wait_until(32'hFFFF);
        brd(8'h20, d); check(d == 16'hFFFF, "R9 low word at FFFF", d, 16'hFFFF);
        repeat (5) @(negedge clk);
        brd(8'h24, d); check(d == 0, "R9 upper word from capture", d, 0);
        brd(8'h20, d); ev = smp_cyc - c0;
        check(d == W'(ev), "R9 low word after carry", d, ev & 16'hFFFF);
        brd(8'h24, d); check(d == 16'h0001, "R9 new capture", d, 1);

        // random mix of R4 R5 R6 R7 R10 R11
        for (int i = 0; i < 30; i++) begin
            int unsigned per  = 1 + ($urandom % 20);
            int unsigned pres = $urandom % 4;
            bit          cont = 1'($urandom % 2);
            bit          aux  = 1'($urandom % 2);
            bit          en   = 1'($urandom % 2);
            bit          fl;
            setup(W'((pres << 8) | (aux << 3) | cont), W'(per), W'(en));
            start_run();
            repeat ($urandom % 60) @(posedge clk);
            #1;
            brd(8'h20, d);
            ev = aux ? (smp_aux - a0) : (smp_cyc - c0);
            check(d == W'(exp_count(ev, pres, per, cont)), "R4 R5 R6 R7 random count", d, exp_count(ev, pres, per, cont));
            brd(8'h1C, d);
            ev = aux ? (smp_aux - a0) : (smp_cyc - c0);
            fl = exp_flag(ev, pres, per);
            check(d == W'(fl), "R10 random status", d, fl);
            check(smp_irq == (fl && en), "R11 random irq", smp_irq, fl && en);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule